// File: doc/BRIEF.md
# Vector Unsigned Clip-Low Stage

This block performs the low-side half of a two-step clip on a vector of eight 16-bit unsigned lanes. A preceding clip-high step, which lies outside the block, leaves five per-lane flag bits: not-equal, carry, extension, compare and clip. Those bits are written into the block's flag store through a load port. When an operation is issued, each lane works out its clip value. That value is t, or the two's-complement negation of t when the lane's carry flag is set. The lane then tests whether s equals the clip value and whether s + t stays below 2^16. It recomputes its compare (low) or clip (high) decision only where the earlier step found equality, and otherwise keeps the stored bit.

Each lane returns either its clip value or s. The vector result is registered and also copied into an accumulator-low register. In the same cycle the not-equal, carry and extension flags are cleared, and the final low and high decisions are written back as the new compare and clip flags. A later clip operation can then continue from them.

Top module: `vcl_clip_low`

## Requirements
- R1: After reset the result, the accumulator-low output and all five flag vectors are zero.
- R2: When `flag_wr` is high and `op_valid` is low, the five flag inputs are stored and appear on the flag outputs one cycle later. Bit i of each flag vector belongs to lane i.
- R3: Lane i uses bits [16i+15:16i] of `src_s` and `src_t`. Its clip value is (2^16 - t) mod 2^16 when its carry flag is 1, and t when it is 0.
- R4: One cycle after `op_valid`, lane i of both `result` and `acc_lo` holds the clip value when the selected decision is 1, and s otherwise. The selected decision is the low decision if the carry flag is 1 and the high decision if it is 0.
- R5: For a lane with not-equal 0, carry 1 and extension 1, the low decision is (s == clip value) OR (s + t < 2^16).
- R6: For a lane with not-equal 0, carry 1 and extension 0, the low decision is (s == clip value) AND (s + t < 2^16).
- R7: For a lane with not-equal 0 and carry 0, the high decision is the unsigned compare s >= clip value.
- R8: A decision that is not recomputed equals the stored flag: the low decision equals the compare flag unless not-equal is 0 and carry is 1, and the high decision equals the clip flag unless not-equal is 0 and carry is 0.
- R9: One cycle after an operation, the not-equal, carry and extension flags are all zero, the compare flag holds the low decision and the clip flag holds the high decision.
- R10: When `op_valid` and `flag_wr` are both high, the operation is performed and the flag load is ignored.
- R11: In a cycle without `op_valid`, `result` and `acc_lo` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Issue one clip-low operation on `src_s`/`src_t` |
| src_s | input | 128 | Eight lanes of operand s |
| src_t | input | 128 | Eight lanes of operand t |
| flag_wr | input | 1 | Load the five flag vectors below |
| ne_in | input | 8 | Not-equal flags to load |
| co_in | input | 8 | Carry flags to load |
| ext_in | input | 8 | Extension flags to load |
| cmp_in | input | 8 | Compare (low) flags to load |
| clp_in | input | 8 | Clip (high) flags to load |
| result | output | 128 | Registered lane results |
| acc_lo | output | 128 | Accumulator-low copy of the result |
| ne_q | output | 8 | Stored not-equal flags |
| co_q | output | 8 | Stored carry flags |
| ext_q | output | 8 | Stored extension flags |
| cmp_q | output | 8 | Stored compare flags |
| clp_q | output | 8 | Stored clip flags |

## Verification
The flag store is the only state that carries from one operation to the next. If a stored compare or clip bit is wrong, it shows on `cmp_q`/`clp_q` in the next cycle. In lanes where not-equal is set, the wrong bit also reaches `result` one cycle after the next operation, because the kept bit then drives the lane select. Operand pairs are chosen so that the sum-carry test, the equality test and the negation of 0 and 0x8000 each flip a lane's output. A wrongly cleared or uncleared carry or extension bit then changes the next result at once.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  // Per-lane view of the five flag bits handed over by the clip-high step.
  typedef struct packed {
    logic ne;   // operands were not equal
    logic co;   // operands had opposite signs (negate path)
    logic ext;  // extension: selects OR/AND combine of zero tests
    logic cmp;  // stored low decision
    logic clp;  // stored high decision
  } lane_flags_t;
endpackage

// File: rtl/vcl_lane.sv
module vcl_lane
  import vcl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] t,
  input  lane_flags_t  f,
  output logic [W-1:0] res,
  output logic         le_o,
  output logic         ge_o
);
  logic [W-1:0] clipv;
  logic [W:0]   sum_w;
  logic         sn, eq, lz, uz, le_calc, ge_calc, pick;

  always_comb begin
    sn      = f.co;
    eq      = ~f.ne;
    clipv   = sn ? (W'(0) - t) : t;
    lz      = (s == clipv);
    sum_w   = {1'b0, s} + {1'b0, t};
    uz      = ~sum_w[W];
    le_calc = f.ext ? (lz | uz) : (lz & uz);
    ge_calc = (s >= clipv);
    le_o    = (eq & sn)  ? le_calc : f.cmp;
    ge_o    = (eq & ~sn) ? ge_calc : f.clp;
    pick    = sn ? le_o : ge_o;
    res     = pick ? clipv : s;
  end
endmodule

// File: rtl/vcl_flag_reg.sv
module vcl_flag_reg #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic             load_en,
  input  logic [LANES-1:0] ne_in,
  input  logic [LANES-1:0] co_in,
  input  logic [LANES-1:0] ext_in,
  input  logic [LANES-1:0] cmp_in,
  input  logic [LANES-1:0] clp_in,
  input  logic [LANES-1:0] le_new,
  input  logic [LANES-1:0] ge_new,
  output logic [LANES-1:0] ne_q,
  output logic [LANES-1:0] co_q,
  output logic [LANES-1:0] ext_q,
  output logic [LANES-1:0] cmp_q,
  output logic [LANES-1:0] clp_q
);
  logic [LANES-1:0] ne_d, co_d, ext_d, cmp_d, clp_d;
  logic             upd;

  always_comb begin
    ne_d  = ne_q;
    co_d  = co_q;
    ext_d = ext_q;
    cmp_d = cmp_q;
    clp_d = clp_q;
    upd   = op_en | load_en;
    if (op_en) begin
      ne_d  = '0;
      co_d  = '0;
      ext_d = '0;
      cmp_d = le_new;
      clp_d = ge_new;
    end else if (load_en) begin
      ne_d  = ne_in;
      co_d  = co_in;
      ext_d = ext_in;
      cmp_d = cmp_in;
      clp_d = clp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q  <= '0;
      co_q  <= '0;
      ext_q <= '0;
      cmp_q <= '0;
      clp_q <= '0;
    end else if (upd) begin
      ne_q  <= ne_d;
      co_q  <= co_d;
      ext_q <= ext_d;
      cmp_q <= cmp_d;
      clp_q <= clp_d;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !op_en) |=> (ne_q == $past(ne_in) && cmp_q == $past(cmp_in)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_en |=> (ne_q == '0 && co_q == '0 && ext_q == '0));

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_en |=> ((cmp_q & $past(ne_q)) == ($past(cmp_q) & $past(ne_q)) &&
               (clp_q & $past(ne_q)) == ($past(clp_q) & $past(ne_q))));

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && load_en) |=> (co_q == '0 && cmp_q == $past(le_new)));
endmodule

// File: rtl/vcl_clip_low.sv
module vcl_clip_low
  import vcl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [LANES*W-1:0]   src_s,
  input  logic [LANES*W-1:0]   src_t,
  input  logic                 flag_wr,
  input  logic [LANES-1:0]     ne_in,
  input  logic [LANES-1:0]     co_in,
  input  logic [LANES-1:0]     ext_in,
  input  logic [LANES-1:0]     cmp_in,
  input  logic [LANES-1:0]     clp_in,
  output logic [LANES*W-1:0]   result,
  output logic [LANES*W-1:0]   acc_lo,
  output logic [LANES-1:0]     ne_q,
  output logic [LANES-1:0]     co_q,
  output logic [LANES-1:0]     ext_q,
  output logic [LANES-1:0]     cmp_q,
  output logic [LANES-1:0]     clp_q
);
  localparam int VW = LANES * W;

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [VW-1:0]    lane_res;
  logic [VW-1:0]    res_d, acc_d;
  logic [LANES-1:0] le_new, ge_new;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_flags_t fl;
    assign fl = '{ne: ne_q[i], co: co_q[i], ext: ext_q[i],
                  cmp: cmp_q[i], clp: clp_q[i]};
    vcl_lane #(.W(W)) u_lane (
      .s    (src_s[i*W +: W]),
      .t    (src_t[i*W +: W]),
      .f    (fl),
      .res  (lane_res[i*W +: W]),
      .le_o (le_new[i]),
      .ge_o (ge_new[i])
    );
  end

  vcl_flag_reg #(.LANES(LANES)) u_flags (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .op_en   (op_valid),
    .load_en (flag_wr),
    .ne_in   (ne_in),
    .co_in   (co_in),
    .ext_in  (ext_in),
    .cmp_in  (cmp_in),
    .clp_in  (clp_in),
    .le_new  (le_new),
    .ge_new  (ge_new),
    .ne_q    (ne_q),
    .co_q    (co_q),
    .ext_q   (ext_q),
    .cmp_q   (cmp_q),
    .clp_q   (clp_q)
  );

  always_comb begin
    res_d = result;
    acc_d = acc_lo;
    if (op_valid) begin
      res_d = lane_res;
      acc_d = lane_res;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      result <= '0;
      acc_lo <= '0;
    end else if (op_valid) begin
      result <= res_d;
      acc_lo <= acc_d;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !op_valid |=> ($stable(result) && $stable(acc_lo)));

  assert_acc_copy_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    op_valid |=> (result == acc_lo));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    op_valid |=> (cmp_q == $past(le_new) && clp_q == $past(ge_new)));
endmodule

// File: tb/sim_vcl_clip_low.sv
module sim_vcl_clip_low;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int VW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0, flag_wr = 1'b0;
  logic [VW-1:0] src_s = '0, src_t = '0;
  logic [N-1:0]  ne_in = '0, co_in = '0, ext_in = '0, cmp_in = '0, clp_in = '0;
  logic [VW-1:0] result, acc_lo;
  logic [N-1:0]  ne_q, co_q, ext_q, cmp_q, clp_q;

  int checks = 0, errors = 0;
  logic [N-1:0]  m_ne = '0, m_co = '0, m_ext = '0, m_cmp = '0, m_clp = '0;
  logic [VW-1:0] m_res = '0;
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  vcl_clip_low u0 (.*);

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Reference step written from the requirements.
  task automatic model_op(input logic [VW-1:0] s, input logic [VW-1:0] t);
    logic [N-1:0] nl, ng;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] sv, tv, cv;
      logic lz, uz, lo, hi;
      sv = s[i*W +: W];
      tv = t[i*W +: W];
      cv = m_co[i] ? 16'(17'h10000 - {1'b0, tv}) : tv;
      lz = (sv == cv);
      uz = ({1'b0, sv} + {1'b0, tv}) < 17'h10000;
      lo = (!m_ne[i] && m_co[i])  ? (m_ext[i] ? (lz || uz) : (lz && uz)) : m_cmp[i];
      hi = (!m_ne[i] && !m_co[i]) ? (sv >= cv) : m_clp[i];
      nl[i] = lo;
      ng[i] = hi;
      m_res[i*W +: W] = (m_co[i] ? lo : hi) ? cv : sv;
    end
    m_ne = '0; m_co = '0; m_ext = '0; m_cmp = nl; m_clp = ng;
  endtask

  task automatic check_flags(input string tag);
    check({tag, " ne"},  VW'(ne_q),  VW'(m_ne));
    check({tag, " co"},  VW'(co_q),  VW'(m_co));
    check({tag, " ext"}, VW'(ext_q), VW'(m_ext));
    check({tag, " cmp"}, VW'(cmp_q), VW'(m_cmp));
    check({tag, " clp"}, VW'(clp_q), VW'(m_clp));
  endtask

  task automatic load(input logic [N-1:0] ne, co, ext, cmp, clp);
    @(negedge clk);
    flag_wr = 1'b1; ne_in = ne; co_in = co; ext_in = ext; cmp_in = cmp; clp_in = clp;
    @(negedge clk);
    flag_wr = 1'b0;
    m_ne = ne; m_co = co; m_ext = ext; m_cmp = cmp; m_clp = clp;
  endtask

  task automatic run_op(input string tag, input logic [VW-1:0] s, input logic [VW-1:0] t);
    @(negedge clk);
    op_valid = 1'b1; src_s = s; src_t = t;
    model_op(s, t);
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " result"}, result, m_res);
    check("R4 acc_lo", acc_lo, m_res);
    check_flags({tag, " R9"});
  endtask

  // Lane pairs that separate the equality test, the carry test and negation.
  function automatic logic [VW-1:0] pack(input logic [W-1:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  task automatic t_reset();
    check("R1 result", result, '0);
    check("R1 acc_lo", acc_lo, '0);
    check_flags("R1");
  endtask

  task automatic t_load();
    load(8'hA5, 8'h3C, 8'h0F, 8'h96, 8'h71);
    check_flags("R2");
  endtask

  task automatic t_ext_or();
    load(8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF);
    run_op("R5", pack(16'd3, 16'd5, 16'd0, 16'h8000, 16'd10, 16'hFFFF, 16'd7, 16'd1),
                 pack(16'hFFFB, 16'hFFFB, 16'd0, 16'h8000, 16'hFFF0, 16'd1, 16'd2, 16'hFFFF));
  endtask

  task automatic t_ext_and();
    load(8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00);
    run_op("R6", pack(16'd3, 16'd5, 16'd0, 16'h8000, 16'd10, 16'hFFFF, 16'd7, 16'd1),
                 pack(16'hFFFB, 16'hFFFB, 16'd0, 16'h8000, 16'hFFF0, 16'd1, 16'd2, 16'hFFFF));
  endtask

  task automatic t_ge();
    load(8'h00, 8'h00, 8'hAA, 8'hFF, 8'h00);
    run_op("R7", pack(16'd4, 16'd5, 16'd6, 16'hFFFF, 16'd0, 16'h8000, 16'h7FFF, 16'd9),
                 pack(16'd5, 16'd5, 16'd5, 16'hFFFF, 16'd1, 16'h7FFF, 16'h8000, 16'd0));
  endtask

  task automatic t_keep();
    load(8'hFF, 8'h0F, 8'h55, 8'h33, 8'h5A);
    run_op("R8", pack(16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8),
                 pack(16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9));
    run_op("R8 after-clear", pack(16'd9, 16'd1, 16'd9, 16'd1, 16'd9, 16'd1, 16'd9, 16'd1),
                             pack(16'd2, 16'd2, 16'd2, 16'd2, 16'd2, 16'd2, 16'd2, 16'd2));
  endtask

  task automatic t_collide();
    load(8'h00, 8'hF0, 8'hF0, 8'h00, 8'h00);
    @(negedge clk);
    op_valid = 1'b1; flag_wr = 1'b1;
    ne_in = 8'hFF; co_in = 8'hFF; ext_in = 8'hFF; cmp_in = 8'hFF; clp_in = 8'hFF;
    src_s = pack(16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3);
    src_t = pack(16'd2, 16'd4, 16'd3, 16'd0, 16'hFFFD, 16'hFFFC, 16'd1, 16'd0);
    model_op(src_s, src_t);
    @(negedge clk);
    op_valid = 1'b0; flag_wr = 1'b0;
    check("R10 result", result, m_res);
    check_flags("R10");
  endtask

  task automatic t_hold();
    logic [VW-1:0] prev;
    prev = m_res;
    @(negedge clk);
    src_s = '1; src_t = '1;
    @(negedge clk);
    @(negedge clk);
    check("R11 result", result, prev);
    check("R11 acc_lo", acc_lo, prev);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 40; k++) begin
      logic [VW-1:0] s, t;
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      load(a[7:0], a[15:8], a[23:16], a[31:24], b[7:0]);
      for (int i = 0; i < N; i++) begin
        logic [31:0] r;
        r = rnd();
        s[i*W +: W] = r[15:0];
        t[i*W +: W] = r[4] ? 16'(17'h10000 - {1'b0, r[15:0]}) : r[31:16];
      end
      run_op("R3/R4 sweep", s, t);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_ext_or();
    t_ext_and();
    t_ge();
    t_keep();
    t_collide();
    t_hold();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule